// File: doc/BRIEF.md
# Multichannel ADC Frame Reader

This block is an SPI master that collects one conversion frame from an eight-channel simultaneous-sampling delta-sigma converter each time the converter reports new data. A falling edge on the active-low data-ready line, after synchronisation, starts a read. The block lowers chip select and clocks 240 bits in each direction. On the outgoing line it sends a fixed command word and then only zero bytes, which serve to produce clocks. On the incoming line it captures ten 24-bit words: a status word, one word per channel, and a CRC word.

A CRC-16 is computed bit-serially over the status and channel bytes and compared with the received check value. When they agree, the eight signed samples are published together with a one-cycle valid strobe. When they differ, a one-cycle error strobe is raised and the samples already on the outputs stay as they were. A data-ready edge that arrives during a read does not start a second read. It sets a sticky overrun flag instead.

Top module: `adc_frame_reader`

## Requirements
- R1: A read begins only on a falling edge of `drdy_ni`, after synchronisation. While idle, `cs_no` is high and `sclk_o` is low. A line held low does not start further reads.
- R2: `cs_no` falls at least one SCLK period (2*CLK_DIV clocks) before the first rising SCLK edge. It rises at least one SCLK period after the last falling edge. `sclk_o` is low whenever `cs_no` is high.
- R3: Each read has exactly 240 SCLK cycles in SPI mode 1. `mosi_o` changes on rising edges and `miso_i` is sampled on falling edges, MSB first.
- R4: The first 24 bits sent are `CMD_WORD` (default 0x000000). All later bits are 0, and `mosi_o` is 0 while idle.
- R5: Received word 0 (status) does not appear on any output. It is included in the CRC.
- R6: Received words 1..8 are channels 0..7, placed at `sample_o[k*24 +: 24]` for channel k.
- R7: The CRC uses polynomial 0x1021 with initial value 0xFFFF, MSB first, no reflection and no final XOR. It covers received bytes 1..27 and is compared with bytes 28 (high) and 29 (low). Byte 30 is clocked but does not affect the outcome.
- R8: On a CRC match, `sample_o` takes the new channel values and `sample_valid_o` pulses for exactly one clock while `cs_no` is high. `sample_o` changes at no other time.
- R9: On a CRC mismatch, `crc_error_o` pulses for exactly one clock and `sample_o` keeps its previous value. The two strobes are never high together.
- R10: A data-ready falling edge while `busy_o` is high does not start a read. It sets `overrun_o`, which stays high until a clock with `clr_overrun_i` high. If both happen in the same clock, the set wins.
- R11: After reset, `cs_no` is high and `sclk_o`, `mosi_o`, `sample_o`, both strobes, `overrun_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drdy_ni | input | 1 | Converter data-ready, active low, asynchronous |
| clr_overrun_i | input | 1 | Clears the sticky overrun flag |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the converter |
| sample_o | output | NUM_CH*WORD_BITS | Channel samples, channel k at bits k*24 +: 24 |
| sample_valid_o | output | 1 | One-clock strobe on a CRC match |
| crc_error_o | output | 1 | One-clock strobe on a CRC mismatch |
| overrun_o | output | 1 | Sticky flag: data-ready edge seen during a read |
| busy_o | output | 1 | A read is in progress |

## Verification
The hardest conditions to reach from the pins are a frame whose only fault lies in the status word, and a frame whose only oddity is a non-zero pad byte. Neither shows up on any data output. The bench's converter model builds these frames deliberately. It computes the CRC over the true status and then flips a status bit, or it fills the pad byte with a pattern. Only the choice between valid and error, together with the held samples, reveals whether the CRC covered the right 27 bytes. Overrun is reached by pulsing data-ready while the model is partway through shifting a frame. The bench then confirms that chip select falls exactly once.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_DONE
  } rd_state_t;
endpackage

// File: rtl/adc_drdy_sync.sv
module adc_drdy_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drdy_ni,
  output logic fall_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], drdy_ni};
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_crc16_ser.sv
module adc_crc16_ser
  import adc_frame_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  assign fb = crc_o[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (init_i) crc_o <= CRC_INIT;
    else if (en_i)   crc_o <= {crc_o[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_frame_pkg::*;
#(
  parameter int                   CLK_DIV   = 2,
  parameter int                   NUM_CH    = 8,
  parameter int                   WORD_BITS = 24,
  parameter logic [WORD_BITS-1:0] CMD_WORD  = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        drdy_ni,
  input  logic                        clr_overrun_i,
  input  logic                        miso_i,
  output logic                        sclk_o,
  output logic                        cs_no,
  output logic                        mosi_o,
  output logic [NUM_CH*WORD_BITS-1:0] sample_o,
  output logic                        sample_valid_o,
  output logic                        crc_error_o,
  output logic                        overrun_o,
  output logic                        busy_o
);
  localparam int FRAME_WORDS = NUM_CH + 2;
  localparam int FRAME_BITS  = FRAME_WORDS * WORD_BITS;
  localparam int CRC_BITS    = (NUM_CH + 1) * WORD_BITS;
  localparam int SMP_W       = NUM_CH * WORD_BITS;
  localparam int BCNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(FRAME_BITS - 1);
  localparam logic [BCNT_W-1:0] BCNT_CRC  = BCNT_W'(CRC_BITS);

  rd_state_t            state_q;
  logic                 drdy_fall, tick, ph_q;
  logic [BCNT_W-1:0]    bit_cnt_q;
  logic [WORD_BITS-1:0] tx_sr_q;
  logic [FRAME_BITS-1:0] rx_sr_q;
  logic [CRC_W-1:0]     crc_calc;
  logic                 crc_init, crc_en, crc_ok;
  logic [SMP_W-1:0]     ch_new;

  adc_drdy_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drdy_ni(drdy_ni),
    .fall_o (drdy_fall)
  );

  adc_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q inside {ST_SETUP, ST_XFER, ST_HOLD}),
    .tick_o(tick)
  );

  assign crc_init = (state_q == ST_IDLE) && drdy_fall;
  // sample on falling SCLK, only over status + channel words
  assign crc_en   = (state_q == ST_XFER) && tick && sclk_o && (bit_cnt_q < BCNT_CRC);

  adc_crc16_ser u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(crc_init),
    .en_i  (crc_en),
    .bit_i (miso_i),
    .crc_o (crc_calc)
  );

  // received CRC sits in the top bytes of the last word; pad byte excluded
  assign crc_ok = (crc_calc == rx_sr_q[WORD_BITS-1 -: CRC_W]);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_new[k*WORD_BITS +: WORD_BITS] =
      rx_sr_q[FRAME_BITS-1-(k+1)*WORD_BITS -: WORD_BITS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      ph_q           <= 1'b0;
      bit_cnt_q      <= '0;
      tx_sr_q        <= '0;
      rx_sr_q        <= '0;
      sclk_o         <= 1'b0;
      mosi_o         <= 1'b0;
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
      crc_error_o    <= 1'b0;
    end else begin
      sample_valid_o <= 1'b0;
      crc_error_o    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (drdy_fall) begin
            state_q   <= ST_SETUP;
            ph_q      <= 1'b0;
            bit_cnt_q <= '0;
            tx_sr_q   <= CMD_WORD;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            ph_q <= ~ph_q;
            if (ph_q) state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!sclk_o) begin
              sclk_o  <= 1'b1;
              mosi_o  <= tx_sr_q[WORD_BITS-1];
              tx_sr_q <= {tx_sr_q[WORD_BITS-2:0], 1'b0};
            end else begin
              sclk_o    <= 1'b0;
              rx_sr_q   <= {rx_sr_q[FRAME_BITS-2:0], miso_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == BCNT_LAST) begin
                state_q <= ST_HOLD;
                ph_q    <= 1'b0;
              end
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
              state_q <= ST_DONE;
              if (crc_ok) begin
                sample_o       <= ch_new;
                sample_valid_o <= 1'b1;
              end else begin
                crc_error_o <= 1'b1;
              end
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              overrun_o <= 1'b0;
    else if (drdy_fall && state_q != ST_IDLE) overrun_o <= 1'b1;
    else if (clr_overrun_i)                   overrun_o <= 1'b0;
  end

  assign cs_no  = !(state_q inside {ST_SETUP, ST_XFER, ST_HOLD});
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int SMP_W = 192
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             busy_o,
  input logic             overrun_o,
  input logic             sample_valid_o,
  input logic             crc_error_o,
  input logic [SMP_W-1:0] sample_o
);
  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r4_mosi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !busy_o) |-> !mosi_o);

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  a_r9_error_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_error_o |=> !crc_error_o);

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_valid_o && crc_error_o));

  a_r8_cs_high_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o || crc_error_o) |-> cs_no);

  a_r8_samples_move_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_o) |-> sample_valid_o);

  a_r10_overrun_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(busy_o));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.SMP_W(NUM_CH*WORD_BITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_no         (cs_no),
  .sclk_o        (sclk_o),
  .mosi_o        (mosi_o),
  .busy_o        (busy_o),
  .overrun_o     (overrun_o),
  .sample_valid_o(sample_valid_o),
  .crc_error_o   (crc_error_o),
  .sample_o      (sample_o)
);

// File: tb/adc_frame_reader_tb.sv
`timescale 1ns/1ps
module adc_frame_reader_tb;
  localparam int CLK_DIV = 2;
  localparam int SMP_W   = 192;
  localparam int FBITS   = 240;

  logic clk = 1'b0, rst_n = 1'b0, drdy_n = 1'b1, clr_ovr = 1'b0, miso = 1'b0;
  logic sclk, cs_n, mosi, s_valid, c_err, ovr, busy;
  logic [SMP_W-1:0] samples;

  always #5 clk = ~clk;

  adc_frame_reader #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .drdy_ni(drdy_n), .clr_overrun_i(clr_ovr),
    .miso_i(miso), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi),
    .sample_o(samples), .sample_valid_o(s_valid), .crc_error_o(c_err),
    .overrun_o(ovr), .busy_o(busy)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [SMP_W-1:0] act, input logic [SMP_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: mode 1, drives on rising SCLK
  logic [FBITS-1:0] tx_frame = '0, slave_sr = '0, mosi_cap = '0;
  int sclk_rises = 0, cs_falls = 0;
  realtime t_cs_fall = 0, t_first_rise = 0, t_last_fall = 0, t_cs_rise = 0;

  always @(negedge cs_n) begin
    slave_sr   = tx_frame;
    sclk_rises = 0;
    cs_falls++;
    t_cs_fall  = $realtime;
  end
  always @(posedge sclk) begin
    if (sclk_rises == 0) t_first_rise = $realtime;
    miso     <= slave_sr[FBITS-1];
    slave_sr  = slave_sr << 1;
    sclk_rises++;
  end
  always @(negedge sclk) begin
    mosi_cap    = {mosi_cap[FBITS-2:0], mosi};
    t_last_fall = $realtime;
  end
  always @(posedge cs_n) t_cs_rise = $realtime;

  // scoreboard
  typedef struct { bit good; logic [SMP_W-1:0] smp; } exp_t;
  exp_t sb_q[$];
  logic [SMP_W-1:0] last_good = '0;

  function automatic logic [15:0] ref_crc(input logic [215:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 27; i++) begin
      c ^= {d[215-8*i -: 8], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  initial begin : monitor
    exp_t it;
    forever begin
      @(negedge clk);
      if (s_valid || c_err) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", "unexpected result strobe", SMP_W'(s_valid), '0);
        end else begin
          it = sb_q.pop_front();
          check(s_valid == it.good && c_err == !it.good, it.good ? "R8" : "R9",
                "strobe kind", SMP_W'({s_valid, c_err}), SMP_W'({it.good, !it.good}));
          check(samples == it.smp, it.good ? "R6" : "R9", "sample_o", samples, it.smp);
        end
      end
    end
  end

  task automatic run_frame(input logic [23:0] status, input logic [SMP_W-1:0] ch,
                           input bit bad_crc, input bit bad_status, input logic [7:0] pad,
                           input bit poke_drdy, input bit hold_low);
    logic [215:0] d;
    logic [15:0]  c;
    exp_t e;
    int falls0;
    d[215:192] = status;
    for (int k = 0; k < 8; k++) d[191-24*k -: 24] = ch[k*24 +: 24];
    c = ref_crc(d);
    if (bad_crc)    c ^= 16'h0100;
    if (bad_status) d[215:208] ^= 8'h01;
    tx_frame = {d, c, pad};
    e.good = !(bad_crc || bad_status);
    e.smp  = e.good ? ch : last_good;
    if (e.good) last_good = ch;
    sb_q.push_back(e);
    falls0 = cs_falls;
    @(negedge clk) drdy_n = 1'b0;
    if (!hold_low) begin
      repeat (4) @(negedge clk);
      drdy_n = 1'b1;
    end
    wait (!cs_n);
    if (poke_drdy) begin
      repeat (60) @(negedge clk);
      drdy_n = 1'b1;
      repeat (4) @(negedge clk);
      drdy_n = 1'b0;
      repeat (4) @(negedge clk);
      drdy_n = 1'b1;
    end
    wait (cs_n);
    repeat (40) @(negedge clk);
    drdy_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sclk_rises == FBITS, "R3", "SCLK cycles per frame", SMP_W'(sclk_rises), SMP_W'(FBITS));
    check(mosi_cap[239:216] == 24'h000000, "R4", "command word", SMP_W'(mosi_cap[239:216]), '0);
    check(mosi_cap[215:0] == '0, "R4", "dummy bytes", SMP_W'(mosi_cap[215:0]), '0);
    check((t_first_rise - t_cs_fall) >= 2*CLK_DIV*10.0, "R2", "cs setup ns",
          SMP_W'(int'(t_first_rise - t_cs_fall)), SMP_W'(2*CLK_DIV*10));
    check((t_cs_rise - t_last_fall) >= 2*CLK_DIV*10.0, "R2", "cs hold ns",
          SMP_W'(int'(t_cs_rise - t_last_fall)), SMP_W'(2*CLK_DIV*10));
    check(cs_falls == falls0 + 1, (poke_drdy || hold_low) ? "R10" : "R1",
          "exactly one read", SMP_W'(cs_falls - falls0), SMP_W'(1));
    check(sb_q.size() == 0, e.good ? "R8" : "R9", "result strobe seen",
          SMP_W'(sb_q.size()), '0);
  endtask

  function automatic logic [SMP_W-1:0] pack8(input logic [23:0] a0, a1, a2, a3,
                                             a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [SMP_W-1:0] p1, p2, p3;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R11", "bus idle in reset",
          SMP_W'({cs_n, sclk, mosi}), SMP_W'(3'b100));
    check(samples == '0 && !s_valid && !c_err && !ovr && !busy, "R11", "outputs in reset",
          samples, '0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check(cs_n && cs_falls == 0, "R1", "no read without data-ready",
          SMP_W'(cs_falls), '0);

    p1 = pack8(24'h123456, 24'hABCDEF, 24'h000001, 24'hFFFFFF,
               24'h7FFFFF, 24'h800000, 24'h5A5A5A, 24'hA5A5A5);
    p2 = pack8(24'h800000, 24'h7FFFFF, 24'h000000, 24'hFFFFFE,
               24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C);
    p3 = pack8(24'hDEAD01, 24'hBEEF02, 24'hC0FFEE, 24'h111111,
               24'h222222, 24'h333333, 24'h444444, 24'h555555);

    run_frame(24'h0500FF, p1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); // R6 R7 R8
    run_frame(24'h000000, p2, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0); // R7 pad ignored
    run_frame(24'h000000, p3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0); // R9 bad CRC
    run_frame(24'hFFFFFF, p3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); // R5 status off outputs
    run_frame(24'h3C3C3C, p1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0); // R5 status in CRC
    run_frame(24'h000000, p2, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1); // R1 held low

    check(!ovr, "R10", "no overrun yet", SMP_W'(ovr), '0);
    run_frame(24'h000123, p1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0); // R10 overrun
    check(ovr, "R10", "overrun sticky", SMP_W'(ovr), SMP_W'(1));
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
    check(!ovr, "R10", "overrun cleared", SMP_W'(ovr), '0);
    check(samples == p1, "R8", "samples held after last frame", samples, p1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule